// File: doc/BRIEF.md
# Dual-Timer Register Window Front End

This block sits between a simple register bus and two timer cores. It takes a 12-bit byte address, so the window is 4 KB. From that address it works out which timer core owns the access. It passes the read or write strobe to that core, together with an offset re-based to the core's own window. It also returns the write data unchanged.

The front end answers several kinds of read itself: a small identification ROM at the top of the window, the two test registers, and every unmapped location. The interrupt levels of the two timers are merged onto a single output. Read data is registered, so each read completes one clock after its strobe.

Top module: `tmr_pair_frontend`

## Requirements
- R1: A write or read at byte offsets 0x000 to 0x01F strobes timer A only, with the 5-bit offset passed through unchanged.
- R2: A write or read at byte offsets 0x020 to 0x03F strobes timer B only, with the offset reduced by 0x20 (the low 5 bits).
- R3: A read is answered on `rd_data` with `rd_valid` high exactly one clock after the `rd_en` cycle, and at no other time.
- R4: Read data for a timer window is the selected timer's `*_rdata`, sampled in the strobe cycle.
- R5: Reads at 0xFE0 to 0xFFC (word aligned) return identification byte k = (offset-0xFE0)>>2 from the sequence 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended into bits 7:0.
- R6: Reads of 0xF00 and 0xF04 (test control and test output) return zero.
- R7: Reads of any other offset above 0x03F return zero.
- R8: Writes above 0x03F strobe neither timer.
- R9: `irq` is high whenever either timer's interrupt input is high. It is combinational.
- R10: After reset, `rd_valid` is low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| irq | output | 1 | Merged interrupt |
| ta_wr | output | 1 | Timer A write strobe |
| ta_rd | output | 1 | Timer A read strobe |
| ta_off | output | 5 | Timer A byte offset |
| ta_wdata | output | 32 | Timer A write data |
| ta_rdata | input | 32 | Timer A read data |
| ta_irq | input | 1 | Timer A interrupt level |
| tb_wr | output | 1 | Timer B write strobe |
| tb_rd | output | 1 | Timer B read strobe |
| tb_off | output | 5 | Timer B byte offset |
| tb_wdata | output | 32 | Timer B write data |
| tb_rdata | input | 32 | Timer B read data |
| tb_irq | input | 1 | Timer B interrupt level |

## Verification
The bench aims at the edges of each region:
- At 0x1F, 0x20, 0x3F and 0x40, a decoder that is off by one would strobe the wrong timer or both.
- Across the ROM, a mistake in the index shift or the byte order would show as swapped or shifted identification bytes.
- Writes above 0x3F are checked for leaks into a timer stub.
- Every read in a stream of back-to-back random reads is compared with its expected value one cycle later. This catches data that lags by one cycle or a `rd_valid` that is held too long.

// File: rtl/tmr_pair_pkg.sv
// Package: shared types and constants for the dual-timer front end.
// Assumes a 12-bit byte address and 32-bit data.
package tmr_pair_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 5;

    // Which responder owns an access.
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_TA   = 3'd1,
        SEL_TB   = 3'd2,
        SEL_ID   = 3'd3,
        SEL_TEST = 3'd4
    } sel_e;

    // Identification byte k; computed by case, eight entries.
    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0: id_byte = 8'h04;
            3'd1: id_byte = 8'h18;
            3'd2: id_byte = 8'h14;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/tmr_addr_decode.sv
// Address decoder: classifies a byte offset into a responder.
// Assumes timer windows are 2**OFF_W bytes each, stacked from 0.
module tmr_addr_decode
    import tmr_pair_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OFF_W
) (
    input  logic [AW-1:0] addr,
    output sel_e          sel,
    output logic [OW-1:0] off,
    output logic [2:0]    id_idx
);
    localparam int WIN      = 1 << OW;
    localparam int ID_BASE  = (1 << AW) - 32;
    localparam int TST_BASE = (1 << AW) - 256;

    // Pick the responder from the offset.
    always_comb begin
        off    = addr[OW-1:0];
        id_idx = addr[4:2];
        if (int'(addr) < WIN)
            sel = SEL_TA;
        else if (int'(addr) < 2 * WIN)
            sel = SEL_TB;
        else if (int'(addr) >= ID_BASE && addr[1:0] == 2'b00)
            sel = SEL_ID;
        else if (int'(addr) == TST_BASE || int'(addr) == TST_BASE + 4)
            sel = SEL_TEST;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/tmr_rd_mux.sv
// Read-return stage: registers the selected data one cycle after a read.
// Assumes the timer read data is valid in the strobe cycle.
module tmr_rd_mux
    import tmr_pair_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  sel_e          sel,
    input  logic [2:0]    id_idx,
    input  logic [DW-1:0] a_data,
    input  logic [DW-1:0] b_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [DW-1:0] nxt;

    // Pick the read data for the current selection.
    always_comb begin
        case (sel)
            SEL_TA:  nxt = a_data;
            SEL_TB:  nxt = b_data;
            SEL_ID:  nxt = {{(DW-8){1'b0}}, id_byte(id_idx)};
            default: nxt = '0;
        endcase
    end

    // Register the data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd;
            if (rd) rd_data <= nxt;
        end
    end

    a_r3_valid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rd_valid);
    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rd_valid);
    a_r6_test_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_TEST) |=> rd_data == '0);
    a_r5_id_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_ID) |=> rd_data[DW-1:8] == '0);
endmodule

// File: rtl/tmr_pair_frontend.sv
// Top: register-window front end for two timer cores with ID ROM and
// merged interrupt. Assumes one access per cycle; write wins no priority
// over read since each goes only to its own strobe.
module tmr_pair_frontend
    import tmr_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              irq,
    output logic              ta_wr,
    output logic              ta_rd,
    output logic [OFF_W-1:0]  ta_off,
    output logic [DATA_W-1:0] ta_wdata,
    input  logic [DATA_W-1:0] ta_rdata,
    input  logic              ta_irq,
    output logic              tb_wr,
    output logic              tb_rd,
    output logic [OFF_W-1:0]  tb_off,
    output logic [DATA_W-1:0] tb_wdata,
    input  logic [DATA_W-1:0] tb_rdata,
    input  logic              tb_irq
);
    sel_e             sel;
    logic [OFF_W-1:0] off;
    logic [2:0]       id_idx;

    tmr_addr_decode #(.AW(ADDR_W), .OW(OFF_W)) u_dec (
        .addr(bus_addr), .sel(sel), .off(off), .id_idx(id_idx)
    );

    // Steer strobes and re-based offsets to the owning timer.
    always_comb begin
        ta_wr    = bus_wr && sel == SEL_TA;
        ta_rd    = bus_rd && sel == SEL_TA;
        tb_wr    = bus_wr && sel == SEL_TB;
        tb_rd    = bus_rd && sel == SEL_TB;
        ta_off   = off;
        tb_off   = off;
        ta_wdata = bus_wdata;
        tb_wdata = bus_wdata;
    end

    // Merge the interrupt levels.
    always_comb irq = ta_irq | tb_irq;

    tmr_rd_mux #(.DW(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(sel), .id_idx(id_idx),
        .a_data(ta_rdata), .b_data(tb_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    a_r1_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ta_wr, ta_rd, tb_wr, tb_rd}) <= 2 && !((ta_wr||ta_rd) && (tb_wr||tb_rd)));
    a_r8_high_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= 12'h040) |-> !(ta_wr || tb_wr));
    a_r9_irq_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_irq || tb_irq) |-> irq);
    a_r4_ta_data: assert property (@(posedge clk) disable iff (!rst_n)
        ta_rd |=> rd_data == $past(ta_rdata));
endmodule

// File: tb/test_tmr_pair_frontend.sv
module test_tmr_pair_frontend;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid, irq;
    logic        ta_wr, ta_rd, tb_wr, tb_rd;
    logic [4:0]  ta_off, tb_off;
    logic [31:0] ta_wdata, tb_wdata;
    logic [31:0] ta_rdata, tb_rdata;
    logic        ta_irq = 0, tb_irq = 0;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Stub timers: read data depends on offset so routing errors show.
    assign ta_rdata = 32'hA000_0000 | {27'd0, ta_off};
    assign tb_rdata = 32'hB000_0000 | {27'd0, tb_off};

    tmr_pair_frontend i_tmr_pair_frontend (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [7:0] ids [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (a < 12'h020) return 32'hA000_0000 | a[4:0];
        if (a < 12'h040) return 32'hB000_0000 | (a - 12'h020);
        if (a >= 12'hFE0 && a[1:0] == 0) return {24'd0, ids[(a - 12'hFE0) >> 2]};
        return 0;
    endfunction

    // Strobe read at addr; check strobes mid-cycle and data after edge.
    task automatic do_read(input logic [11:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1;
        chk({req, " ta_rd"}, ta_rd, a < 12'h020);
        chk({req, " tb_rd"}, tb_rd, a >= 12'h020 && a < 12'h040);
        @(negedge clk);
        bus_rd = 0;
        chk({req, " R3 valid"}, rd_valid, 1);
        chk({req, " data"}, rd_data, exp_rd(a));
    endtask

    task automatic do_write(input logic [11:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_wr = 1; bus_wdata = $urandom;
        #1;
        chk({req, " ta_wr"}, ta_wr, a < 12'h020);
        chk({req, " tb_wr"}, tb_wr, a >= 12'h020 && a < 12'h040);
        if (a < 12'h020) begin
            chk({req, " ta_off"}, ta_off, a[4:0]);
            chk({req, " ta_wdata"}, ta_wdata, bus_wdata);
        end else if (a < 12'h040) begin
            chk({req, " tb_off"}, tb_off, a - 12'h020);
            chk({req, " tb_wdata"}, tb_wdata, bus_wdata);
        end
        @(negedge clk);
        bus_wr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R10 valid", rd_valid, 0);
        chk("R10 data", rd_data, 0);
        rst_n = 1;
        // Boundaries R1/R2
        do_write(12'h000, "R1"); do_write(12'h01F, "R1");
        do_write(12'h020, "R2"); do_write(12'h03F, "R2");
        do_write(12'h040, "R8"); do_write(12'hF00, "R8"); do_write(12'hFFC, "R8");
        do_read(12'h01C, "R1 R4"); do_read(12'h024, "R2 R4");
        do_read(12'h03F, "R2 R4"); do_read(12'h040, "R7");
        for (int k = 0; k < 8; k++) do_read(12'hFE0 + 12'(k*4), "R5");
        do_read(12'hF00, "R6"); do_read(12'hF04, "R6");
        do_read(12'h800, "R7"); do_read(12'hFE2, "R7");
        // Idle: no valid
        @(negedge clk); chk("R3 idle", rd_valid, 0);
        // Back-to-back random reads
        begin
            logic [11:0] prev;
            @(negedge clk);
            prev = 12'($urandom); bus_addr = prev; bus_rd = 1;
            for (int i = 0; i < 200; i++) begin
                logic [11:0] a;
                case ($urandom % 4)
                    0: a = 12'($urandom % 64);
                    1: a = 12'hFE0 + 12'(($urandom % 8) * 4);
                    default: a = 12'($urandom);
                endcase
                @(negedge clk);
                chk("R3 R4 stream valid", rd_valid, 1);
                chk("R4 R5 R7 stream data", rd_data, exp_rd(prev));
                prev = a; bus_addr = a;
            end
            @(negedge clk); bus_rd = 0;
            chk("R4 stream last", rd_data, exp_rd(prev));
            @(negedge clk); chk("R3 drop", rd_valid, 0);
        end
        // R9 interrupt merge, all four combos
        for (int m = 0; m < 4; m++) begin
            ta_irq = m[0]; tb_irq = m[1]; #1;
            chk("R9 irq", irq, m[0] | m[1]);
        end
        for (int i = 0; i < 50; i++) do_write(12'($urandom), "R1 R2 R8 random");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule